// File: doc/BRIEF.md
# Least-Recently-Used Frame Victim Selector

This block keeps the recency order of a small, fixed pool of page frames and, on request, names the frame to hand out next. A free-running logical clock advances by one on every recorded event. Each recorded event copies the current clock value into the touched frame's time-of-use stamp. The events are a reference to an occupied frame and the allocation of a frame. When an allocation is requested, the block looks at all frames at once. If any frame is empty, the lowest-numbered empty frame is chosen. Otherwise the occupied frame with the smallest stamp is chosen, which is the least recently used one. Each frame also carries a modify bit, so the caller learns whether the chosen frame must be written back before it is reused.

References arrive on a valid/ready stream carrying a frame index and a write flag. A reference to a frame that is currently empty is accepted and ignored. Allocation requests use a valid/ready pair. The chosen frame leaves on a registered valid/ready output one cycle after the request is accepted. Back-pressure works as follows. While a victim is held on the output and not yet taken, neither allocations nor references are accepted, so the recency state cannot change under a reported victim. An allocation request has priority over a reference presented in the same cycle. The stamp clock is finite. When it would pass its maximum, all occupied stamps are rewritten to their rank order and the clock restarts just above them, so recency order survives the wrap.

Top module: `lru_victim_sel`

## Requirements
- R1: After reset all frames are empty and clean, `vic_valid` is 0, and both `alloc_ready` and `ref_ready` are 1.
- R2: While any frame is empty, an allocation chooses the lowest-numbered empty frame and reports `vic_evict` = 0 and `vic_dirty` = 0.
- R3: When every frame is occupied, an allocation chooses the frame whose most recent event (accepted reference or allocation) is oldest and reports `vic_evict` = 1.
- R4: An accepted reference with `ref_write` = 1 to an occupied frame sets that frame's modify bit. The victim's `vic_dirty` equals that bit. Allocating a frame clears its modify bit.
- R5: `vic_valid` rises in the cycle after an allocation handshake and holds `vic_frame`, `vic_dirty` and `vic_evict` unchanged until `vic_ready` is 1. While `vic_valid` is 1, `alloc_ready` and `ref_ready` are 0.
- R6: While `alloc_valid` is 1, `ref_ready` is 0, and a reference presented in that cycle has no effect on recency or modify state.
- R7: When the stamp clock passes its maximum value, stamps are renormalised by rank, and later victim choices keep following true least-recently-used order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A reference is presented |
| ref_ready | output | 1 | The reference is accepted this cycle |
| ref_frame | input | $clog2(NFRAMES) | Frame index being referenced |
| ref_write | input | 1 | The reference is a write |
| alloc_valid | input | 1 | An allocation is requested |
| alloc_ready | output | 1 | The allocation is accepted this cycle |
| vic_valid | output | 1 | A chosen frame is presented |
| vic_ready | input | 1 | The consumer takes the chosen frame |
| vic_frame | output | $clog2(NFRAMES) | Index of the chosen frame |
| vic_dirty | output | 1 | The chosen frame must be written back |
| vic_evict | output | 1 | The chosen frame held a page (replacement, not fill) |

## Verification
The bench runs a 4-frame, 5-bit-stamp configuration. A fill phase from an empty pool separates the free-frame path from the replacement path. A directed sweep makes each frame in turn the oldest, once with a write and once without, which shows whether the oldest stamp is found at every tree position and whether the modify bit follows the right frame. A long pseudo-random mix of references, writes, stalled outputs and colliding reference/allocation pairs runs the stamp clock through many wraps. Its results are compared with a model that uses unbounded sequence numbers, so any error in rank renormalisation or in reference priority shows up as a wrong victim or a wrong dirty flag.

// File: rtl/lru_pkg.sv
`timescale 1ns/1ps
package lru_pkg;
  // smallest pool the selector supports
  localparam int unsigned LRU_MIN_FRAMES = 2;

  // leaf count of the comparison tree: next power of two at or above n
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/lru_min_tree.sv
`timescale 1ns/1ps
module lru_min_tree
  import lru_pkg::*;
#(
  parameter int unsigned NFRAMES = 4,
  parameter int unsigned STAMP_W = 16,
  localparam int unsigned FW = $clog2(NFRAMES)
) (
  input  logic [NFRAMES-1:0]              occ,
  input  logic [NFRAMES-1:0][STAMP_W-1:0] stamps,
  output logic [FW-1:0]                   win_idx
);
  localparam int unsigned LEAVES = pow2_ceil(NFRAMES);
  localparam int unsigned NODES  = 2 * LEAVES - 1;
  localparam int unsigned KW     = STAMP_W + 1;

  // key: empty frames sort below every occupied one, and all empties tie
  logic [KW-1:0] nkey [NODES];
  logic [FW-1:0] nidx [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NFRAMES) begin : g_real
      assign nkey[LEAVES-1+i] = occ[i] ? {1'b1, stamps[i]} : '0;
    end else begin : g_pad
      assign nkey[LEAVES-1+i] = '1;
    end
    assign nidx[LEAVES-1+i] = FW'(i);
  end

  // ties keep the left child, which always holds the lower frame index
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic pick_r;
    assign pick_r  = nkey[2*n+2] < nkey[2*n+1];
    assign nkey[n] = pick_r ? nkey[2*n+2] : nkey[2*n+1];
    assign nidx[n] = pick_r ? nidx[2*n+2] : nidx[2*n+1];
  end

  assign win_idx = nidx[0];
endmodule

// File: rtl/lru_rank.sv
`timescale 1ns/1ps
module lru_rank #(
  parameter int unsigned NFRAMES = 4,
  parameter int unsigned STAMP_W = 16,
  localparam int unsigned FW = $clog2(NFRAMES)
) (
  input  logic [NFRAMES-1:0]              occ,
  input  logic [NFRAMES-1:0][STAMP_W-1:0] stamps,
  input  logic [FW-1:0]                   excl,
  output logic [NFRAMES-1:0][STAMP_W-1:0] rank
);
  // rank of each frame among the occupied frames other than excl
  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    always_comb begin
      logic [STAMP_W-1:0] cnt;
      cnt = '0;
      for (int h = 0; h < NFRAMES; h++) begin
        if (h != g && FW'(h) != excl && occ[h] && stamps[h] < stamps[g])
          cnt = cnt + STAMP_W'(1);
      end
      rank[g] = cnt;
    end
  end
endmodule

// File: rtl/lru_victim_sel.sv
`timescale 1ns/1ps
module lru_victim_sel
  import lru_pkg::*;
#(
  parameter int unsigned NFRAMES = 4,
  parameter int unsigned STAMP_W = 16,
  localparam int unsigned FW = $clog2(NFRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_valid,
  output logic          ref_ready,
  input  logic [FW-1:0] ref_frame,
  input  logic          ref_write,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic          vic_valid,
  input  logic          vic_ready,
  output logic [FW-1:0] vic_frame,
  output logic          vic_dirty,
  output logic          vic_evict
);
  localparam logic [STAMP_W-1:0] STAMP_MAX  = '1;
  localparam logic [STAMP_W-1:0] RENORM_TOP = STAMP_W'(NFRAMES - 1);
  localparam logic [STAMP_W-1:0] CLK_RESUME = STAMP_W'(NFRAMES);

  logic [NFRAMES-1:0]              occ_q, dirty_q;
  logic [NFRAMES-1:0][STAMP_W-1:0] stamp_q, rank_w;
  logic [STAMP_W-1:0]              clk_q;
  logic [FW-1:0]                   win_w, ev_frame;
  logic                            alloc_fire, ref_hit, ev_fire, wrap;

  // ---------------- handshakes ----------------
  assign alloc_ready = !vic_valid;
  assign ref_ready   = !vic_valid && !alloc_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign ref_hit     = ref_valid && ref_ready &&
                       (int'(ref_frame) < int'(NFRAMES)) && occ_q[ref_frame];

  // one recorded event per cycle at most
  assign ev_fire  = alloc_fire || ref_hit;
  assign ev_frame = alloc_fire ? win_w : ref_frame;
  assign wrap     = ev_fire && (clk_q == STAMP_MAX);

  // ---------------- choice and renormalisation ----------------
  lru_min_tree #(.NFRAMES(NFRAMES), .STAMP_W(STAMP_W)) u_tree (
    .occ     (occ_q),
    .stamps  (stamp_q),
    .win_idx (win_w)
  );

  lru_rank #(.NFRAMES(NFRAMES), .STAMP_W(STAMP_W)) u_rank (
    .occ    (occ_q),
    .stamps (stamp_q),
    .excl   (ev_frame),
    .rank   (rank_w)
  );

  // ---------------- logical clock ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clk_q <= '0;
    else if (wrap)    clk_q <= CLK_RESUME;
    else if (ev_fire) clk_q <= clk_q + STAMP_W'(1);
  end

  // ---------------- per-frame state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      dirty_q <= '0;
      stamp_q <= '0;
    end else begin
      for (int g = 0; g < NFRAMES; g++) begin
        if (ev_fire && ev_frame == FW'(g))
          stamp_q[g] <= wrap ? RENORM_TOP : clk_q;
        else if (wrap)
          stamp_q[g] <= occ_q[g] ? rank_w[g] : '0;

        if (alloc_fire && win_w == FW'(g)) begin
          occ_q[g]   <= 1'b1;
          dirty_q[g] <= 1'b0;
        end else if (ref_hit && ref_write && ref_frame == FW'(g)) begin
          dirty_q[g] <= 1'b1;
        end
      end
    end
  end

  // ---------------- registered victim output ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_frame <= '0;
      vic_dirty <= 1'b0;
      vic_evict <= 1'b0;
    end else if (alloc_fire) begin
      vic_valid <= 1'b1;
      vic_frame <= win_w;
      vic_dirty <= occ_q[win_w] && dirty_q[win_w];
      vic_evict <= occ_q[win_w];
    end else if (vic_valid && vic_ready) begin
      vic_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lru_victim_sel_chk.sv
`timescale 1ns/1ps
module lru_victim_sel_chk #(
  parameter int unsigned NFRAMES = 4,
  parameter int unsigned STAMP_W = 16,
  localparam int unsigned FW = $clog2(NFRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_valid,
  input logic          ref_ready,
  input logic [FW-1:0] ref_frame,
  input logic          ref_write,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic          vic_valid,
  input logic          vic_ready,
  input logic [FW-1:0] vic_frame,
  input logic          vic_dirty,
  input logic          vic_evict
);
  // R5
  vic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && !vic_ready |=> vic_valid && $stable(vic_frame) &&
                                $stable(vic_dirty) && $stable(vic_evict));

  // R5
  vic_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> !alloc_ready && !ref_ready);

  // R5
  vic_follows_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> vic_valid);

  // R5
  vic_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vic_valid) |-> $past(alloc_valid && alloc_ready));

  // R6
  alloc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !ref_ready);

  // R2
  fill_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && !vic_evict |-> !vic_dirty);
endmodule

bind lru_victim_sel lru_victim_sel_chk #(.NFRAMES(NFRAMES), .STAMP_W(STAMP_W)) u_chk (.*);

// File: tb/lru_victim_sel_test.sv
`timescale 1ns/1ps
module lru_victim_sel_test;
  localparam int NF = 4;
  localparam int SW = 5;
  localparam int FW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0, ref_write = 1'b0;
  logic [FW-1:0] ref_frame = '0;
  logic          alloc_valid = 1'b0, vic_ready = 1'b0;
  logic          ref_ready, alloc_ready, vic_valid, vic_dirty, vic_evict;
  logic [FW-1:0] vic_frame;

  always #2.5 clk = ~clk; // 200 MHz

  lru_victim_sel #(.NFRAMES(NF), .STAMP_W(SW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_frame(ref_frame), .ref_write(ref_write),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_frame(vic_frame),
    .vic_dirty(vic_dirty), .vic_evict(vic_evict)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int m_occ[NF], m_dirty[NF], m_last[NF];
  int seq = 0; // unbounded event counter: the model never wraps
  int unsigned lf = 32'h1D2C3B4A;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
    return lf;
  endfunction

  function automatic int model_victim();
    int best = -1;
    for (int i = 0; i < NF; i++) if (m_occ[i] == 0 && best < 0) best = i;
    if (best >= 0) return best;
    best = 0;
    for (int i = 1; i < NF; i++) if (m_last[i] < m_last[best]) best = i;
    return best;
  endfunction

  // every task starts and ends just after a falling edge
  task automatic do_ref(input int f, input bit w);
    ref_valid = 1'b1; ref_frame = FW'(f); ref_write = w;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
    if (m_occ[f] != 0) begin
      m_last[f] = seq++;
      if (w) m_dirty[f] = 1;
    end
  endtask

  task automatic do_alloc(input bit stall, input bit clash);
    int ef, ee, ed;
    string tag;
    ef = model_victim();
    ee = m_occ[ef];
    ed = (m_occ[ef] != 0 && m_dirty[ef] != 0) ? 1 : 0;
    tag = (ee == 0) ? "R2 frame" : ((seq > 32) ? "R7 frame" : "R3 frame");
    alloc_valid = 1'b1;
    if (clash) begin // R6: colliding reference must be dropped
      ref_valid = 1'b1; ref_frame = FW'((ef + 1) % NF); ref_write = 1'b1;
    end
    #1;
    chk("R5 alloc_ready idle", int'(alloc_ready), 1);
    chk("R6 ref_ready under alloc", int'(ref_ready), 0);
    @(negedge clk);
    alloc_valid = 1'b0; ref_valid = 1'b0; ref_write = 1'b0;
    chk("R5 vic_valid next cycle", int'(vic_valid), 1);
    chk(tag, int'(vic_frame), ef);
    chk(ee == 0 ? "R2 evict" : "R3 evict", int'(vic_evict), ee);
    chk("R4 dirty", int'(vic_dirty), ed);
    chk("R5 inputs blocked", int'(alloc_ready) + int'(ref_ready), 0);
    if (stall) begin
      @(negedge clk);
      chk("R5 held valid", int'(vic_valid), 1);
      chk("R5 held frame", int'(vic_frame), ef);
      chk("R5 held dirty", int'(vic_dirty), ed);
    end
    vic_ready = 1'b1;
    @(negedge clk);
    vic_ready = 1'b0;
    chk("R5 vic_valid drops", int'(vic_valid), 0);
    m_occ[ef] = 1; m_dirty[ef] = 0; m_last[ef] = seq++;
  endtask

  initial begin
    #500000; // 100k cycles
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) begin m_occ[i] = 0; m_dirty[i] = 0; m_last[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 vic_valid", int'(vic_valid), 0);
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 ref_ready", int'(ref_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // write to an empty frame: accepted and ignored
    do_ref(2, 1'b1);

    // fill from empty: R2 frames 0..3, clean, no eviction
    for (int i = 0; i < NF; i++) do_alloc(i[0], 1'b0);

    // directed sweep: make each frame the oldest, with and without a write
    for (int v = 0; v < NF; v++) begin
      for (int w = 0; w < 2; w++) begin
        do_ref(v, w[0]);
        for (int k = 1; k < NF; k++) do_ref((v + k) % NF, 1'b0);
        do_alloc(1'b0, 1'b0); // expected victim v, dirty w (R3, R4)
      end
    end

    // long mix: runs the 5-bit stamp clock through many wraps (R7)
    for (int r = 0; r < 400; r++) begin
      int nrefs;
      nrefs = int'(rnd() % 6);
      for (int k = 0; k < nrefs; k++) begin
        int unsigned x;
        x = rnd();
        do_ref(int'(x % NF), x[8] & x[9]);
      end
      do_alloc(rnd() % 3 == 0, rnd() % 4 == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule